// File: doc/BRIEF.md
# Frame-Locked Line Clock Loop

This block recovers a line-rate clock from a master clock that runs a little faster than nominal. All logic runs on one system clock. An enable input marks the system cycles that stand for one half-period of the master clock. Sixteen enabled half-periods form one line-clock period. One hundred and ninety-three line periods form the local 8 kHz frame, which is marked by a one-cycle tick and by a frame-rate level output.

The loop can only slow the local frame down. Once per frame, the falling edge of the 8 kHz reference (after synchronization) samples where the local frame counter stands. If the edge arrives in the first half of the local frame, the local frame is running ahead. The loop then adds one extra half-period at two fixed lines of every following frame, so each frame is one master period longer. If the edge arrives in the second half, the master is divided unaltered and its excess speed pulls the frame forward. This bang-bang control makes the frame tick dither around the reference edge.

In divide mode the loop is bypassed. The frame counter then counts rising edges of an external line-rate clock, with a wrap length of 193 or 256. The line-clock output simply follows that external clock.

Top module: `trunk_dpll`

## Requirements
- R1: While rst_n is low, line_clk, frame_8k and frame_tick are 0 and line_clk_n is 1; after release the dividers restart from zero.
- R2: In tracking mode (div_mode=0), line_clk has a period of 16 enabled ticks (half_en=1 cycles). It is low for the first 8 and high for the next 8, so it first goes high after the 8th enabled tick following reset.
- R3: line_clk_n is always the inverse of line_clk.
- R4: frame_tick is a pulse one system cycle wide. Without correction it repeats every 193 x 16 = 3088 enabled ticks.
- R5: In tracking mode, cycles with half_en=0 do not advance the dividers: line_clk holds its value, and with half_en high on every other cycle the frame spacing becomes 6176 system cycles.
- R6: ref_8k is synchronized with two flops, and only its falling edge is used. A falling edge that finds the frame count below 96 selects slowing: every following frame takes 3090 enabled ticks, one extra tick each at line 0 and line 96. A falling edge at count 96 or above clears this, and frames return to 3088 ticks.
- R7: With ref_8k falling every 3089 cycles (half_en always 1), the frame tick pulls in and then stays within 24 cycles of each reference falling edge.
- R8: In divide mode (div_mode=1), line_clk equals ext_clk delayed by three system cycles. The frame count advances on each synchronized rising edge of ext_clk and wraps after 193 edges (div_sel=0) or 256 edges (div_sel=1), giving one frame_tick per wrap.
- R9: frame_8k is high while the frame count is at least N-128 (N = 193, or 256 in divide mode with div_sel=1). This gives 128 of 193 (about 66%) or 128 of 256 (50%) duty, and frame_8k is low in the cycle frame_tick is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the master clock rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| half_en | input | 1 | Marks a cycle that is one master half-period |
| ref_8k | input | 1 | 8 kHz reference, falling edge is the lock point |
| ext_clk | input | 1 | External line-rate clock used in divide mode |
| div_mode | input | 1 | 1 selects divide mode, 0 selects tracking |
| div_sel | input | 1 | Divide ratio: 0 gives 193, 1 gives 256 |
| line_clk | output | 1 | Recovered line clock |
| line_clk_n | output | 1 | Inverted line clock |
| frame_8k | output | 1 | Frame-rate level output |
| frame_tick | output | 1 | One-cycle pulse at each frame wrap |

## Verification
A stuck or mis-set slow decision is visible at the very next frame, because the spacing of frame_tick is then 3088 where 3090 is due, or the reverse. A corrupted line or half-period counter moves the line_clk edges within 16 cycles and moves the frame_8k threshold within one frame. In divide mode, a wrong ratio or a missed edge count appears as a wrong frame_8k level or a missing tick at the exact edge count where the wrap or threshold should fall.

// File: rtl/trunk_dpll_pkg.sv
package trunk_dpll_pkg;

    typedef enum logic {
        MODE_TRACK  = 1'b0,
        MODE_DIVIDE = 1'b1
    } dpll_mode_e;

    localparam int DEF_HALF_TICKS  = 16;
    localparam int DEF_FRAME_LINES = 193;
    localparam int DEF_ALT_LINES   = 256;
    localparam int DEF_HIGH_LINES  = 128;
    localparam int DEF_STRETCH_A   = 0;
    localparam int DEF_STRETCH_B   = 96;
    localparam int DEF_SYNC_STAGES = 2;

endpackage

// File: rtl/trunk_dpll_edge_sync.sv
module trunk_dpll_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic lvl,
    output logic rise,
    output logic fall
);
    localparam int TOTAL = STAGES + 1;

    logic [TOTAL-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[0] <= 1'b0;
        else        chain_q[0] <= din;
    end

    for (genvar i = 1; i < TOTAL; i++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q[i] <= 1'b0;
            else        chain_q[i] <= chain_q[i-1];
        end
    end

    assign lvl  = chain_q[STAGES-1];
    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
    assign fall = ~chain_q[STAGES-1] & chain_q[STAGES];

endmodule

// File: rtl/trunk_dpll_engine.sv
module trunk_dpll_engine
    import trunk_dpll_pkg::*;
#(
    parameter int HALF_TICKS  = DEF_HALF_TICKS,
    parameter int FRAME_LINES = DEF_FRAME_LINES,
    parameter int ALT_LINES   = DEF_ALT_LINES,
    parameter int HIGH_LINES  = DEF_HIGH_LINES,
    parameter int STRETCH_A   = DEF_STRETCH_A,
    parameter int STRETCH_B   = DEF_STRETCH_B
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       half_en,
    input  logic       ref_fall,
    input  logic       ext_lvl,
    input  logic       ext_rise,
    input  dpll_mode_e mode,
    input  logic       div_sel,
    output logic       line_clk,
    output logic       frame_8k,
    output logic       frame_tick
);
    localparam int MAX_LINES = (FRAME_LINES > ALT_LINES) ? FRAME_LINES : ALT_LINES;
    localparam int HW        = $clog2(HALF_TICKS);
    localparam int CW        = $clog2(MAX_LINES);

    localparam logic [HW-1:0] HCNT_LAST   = HW'(HALF_TICKS - 1);
    localparam logic [HW-1:0] LINE_HIGH_C = HW'(HALF_TICKS / 2);
    localparam logic [CW-1:0] MAIN_LAST   = CW'(FRAME_LINES - 1);
    localparam logic [CW-1:0] ALT_LAST    = CW'(ALT_LINES - 1);
    localparam logic [CW-1:0] MAIN_HIGH   = CW'(FRAME_LINES - HIGH_LINES);
    localparam logic [CW-1:0] ALT_HIGH    = CW'(ALT_LINES - HIGH_LINES);
    localparam logic [CW-1:0] MID_FRAME   = CW'(FRAME_LINES / 2);
    localparam logic [CW-1:0] PT_A        = CW'(STRETCH_A);
    localparam logic [CW-1:0] PT_B        = CW'(STRETCH_B);

    typedef struct packed {
        logic [HW-1:0] hcnt;
        logic [CW-1:0] lcnt;
        logic          held;
        logic          slow;
        logic          line;
        logic          tick;
    } state_t;

    state_t st_d, st_q;
    logic [CW-1:0] last_line;
    logic [CW-1:0] high_from;
    logic          at_stretch;

    always_comb begin
        if (mode == MODE_DIVIDE && div_sel) begin
            last_line = ALT_LAST;
            high_from = ALT_HIGH;
        end else begin
            last_line = MAIN_LAST;
            high_from = MAIN_HIGH;
        end
        at_stretch = (st_q.lcnt == PT_A) || (st_q.lcnt == PT_B);

        st_d      = st_q;
        st_d.tick = 1'b0;

        if (mode == MODE_DIVIDE) begin
            st_d.hcnt = '0;
            st_d.held = 1'b0;
            st_d.line = ext_lvl;
            if (ext_rise) begin
                if (st_q.lcnt >= last_line) begin
                    st_d.lcnt = '0;
                    st_d.tick = 1'b1;
                end else begin
                    st_d.lcnt = st_q.lcnt + 1'b1;
                end
            end
        end else begin
            if (ref_fall) begin
                st_d.slow = (st_q.lcnt < MID_FRAME);
            end
            if (half_en) begin
                if (st_q.hcnt == HCNT_LAST) begin
                    if (st_q.slow && !st_q.held && at_stretch) begin
                        st_d.held = 1'b1;
                    end else begin
                        st_d.held = 1'b0;
                        st_d.hcnt = '0;
                        if (st_q.lcnt >= last_line) begin
                            st_d.lcnt = '0;
                            st_d.tick = 1'b1;
                        end else begin
                            st_d.lcnt = st_q.lcnt + 1'b1;
                        end
                    end
                end else begin
                    st_d.hcnt = st_q.hcnt + 1'b1;
                end
            end
            st_d.line = (st_d.hcnt >= LINE_HIGH_C);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign line_clk   = st_q.line;
    assign frame_tick = st_q.tick;
    assign frame_8k   = (st_q.lcnt >= high_from);

endmodule

// File: rtl/trunk_dpll.sv
module trunk_dpll
    import trunk_dpll_pkg::*;
#(
    parameter int HALF_TICKS  = DEF_HALF_TICKS,
    parameter int FRAME_LINES = DEF_FRAME_LINES,
    parameter int ALT_LINES   = DEF_ALT_LINES,
    parameter int HIGH_LINES  = DEF_HIGH_LINES,
    parameter int STRETCH_A   = DEF_STRETCH_A,
    parameter int STRETCH_B   = DEF_STRETCH_B,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic clk,
    input  logic rst_n,
    input  logic half_en,
    input  logic ref_8k,
    input  logic ext_clk,
    input  logic div_mode,
    input  logic div_sel,
    output logic line_clk,
    output logic line_clk_n,
    output logic frame_8k,
    output logic frame_tick
);
    logic       ref_lvl, ref_rise, ref_fall;
    logic       ext_lvl, ext_rise, ext_fall;
    dpll_mode_e mode;

    assign mode = div_mode ? MODE_DIVIDE : MODE_TRACK;

    trunk_dpll_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ref_8k),
        .lvl  (ref_lvl),
        .rise (ref_rise),
        .fall (ref_fall)
    );

    trunk_dpll_edge_sync #(.STAGES(SYNC_STAGES)) u_ext_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (ext_clk),
        .lvl  (ext_lvl),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    trunk_dpll_engine #(
        .HALF_TICKS (HALF_TICKS),
        .FRAME_LINES(FRAME_LINES),
        .ALT_LINES  (ALT_LINES),
        .HIGH_LINES (HIGH_LINES),
        .STRETCH_A  (STRETCH_A),
        .STRETCH_B  (STRETCH_B)
    ) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_en   (half_en),
        .ref_fall  (ref_fall),
        .ext_lvl   (ext_lvl),
        .ext_rise  (ext_rise),
        .mode      (mode),
        .div_sel   (div_sel),
        .line_clk  (line_clk),
        .frame_8k  (frame_8k),
        .frame_tick(frame_tick)
    );

    assign line_clk_n = ~line_clk;

endmodule

// File: rtl/trunk_dpll_checker.sv
module trunk_dpll_checker (
    input logic clk,
    input logic rst_n,
    input logic half_en,
    input logic ext_clk,
    input logic div_mode,
    input logic line_clk,
    input logic frame_8k,
    input logic frame_tick
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |-> (!line_clk && !frame_8k && !frame_tick)); // R1

    AST_TICK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |=> !frame_tick); // R4

    AST_TICK_AT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        frame_tick |-> (!frame_8k && $past(frame_8k))); // R9

    AST_FREEZE_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(div_mode) && !$past(div_mode, 2) && !$past(half_en))
        |-> $stable(line_clk)); // R5

    AST_DIV_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(div_mode) && $past(rst_n) && $past(rst_n, 2) && $past(rst_n, 3))
        |-> (line_clk == $past(ext_clk, 3))); // R8

endmodule

bind trunk_dpll trunk_dpll_checker u_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .half_en   (half_en),
    .ext_clk   (ext_clk),
    .div_mode  (div_mode),
    .line_clk  (line_clk),
    .frame_8k  (frame_8k),
    .frame_tick(frame_tick)
);

// File: tb/tb_trunk_dpll.sv
`timescale 1ns/1ps
module tb_trunk_dpll;

    logic clk = 1'b0;
    logic rst_n, half_en, ref_8k, ext_clk, div_mode, div_sel;
    logic line_clk, line_clk_n, frame_8k, frame_tick;

    int cyc = 0;
    int n_chk = 0;
    int n_bad = 0;
    int tick_cnt = 0;
    int last_tick = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (frame_tick) begin
            tick_cnt  <= tick_cnt + 1;
            last_tick <= cyc;
        end
    end

    trunk_dpll dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .half_en   (half_en),
        .ref_8k    (ref_8k),
        .ext_clk   (ext_clk),
        .div_mode  (div_mode),
        .div_sel   (div_sel),
        .line_clk  (line_clk),
        .line_clk_n(line_clk_n),
        .frame_8k  (frame_8k),
        .frame_tick(frame_tick)
    );

    typedef struct packed {
        logic       sel;
        logic [9:0] edges;
        logic       exp8k;
        logic [1:0] ticks;
    } vec_t;

    localparam int NVEC = 8;
    localparam vec_t VECS [NVEC] = '{
        '{1'b0, 10'd64,  1'b0, 2'd0},
        '{1'b0, 10'd65,  1'b1, 2'd0},
        '{1'b0, 10'd192, 1'b1, 2'd0},
        '{1'b0, 10'd193, 1'b0, 2'd1},
        '{1'b1, 10'd127, 1'b0, 2'd0},
        '{1'b1, 10'd128, 1'b1, 2'd0},
        '{1'b1, 10'd255, 1'b1, 2'd0},
        '{1'b1, 10'd256, 1'b0, 2'd1}
    };

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic dm, input logic sel);
        rst_n    = 1'b0;
        div_mode = dm;
        div_sel  = sel;
        half_en  = 1'b1;
        ref_8k   = 1'b1;
        ext_clk  = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_tick(output int t);
        @(negedge clk);
        while (!frame_tick) @(negedge clk);
        t = cyc;
    endtask

    initial begin
        wait (cyc >= 199000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int t1, t2, t3, t4, t5, t6, t7, t8;
        int fall_at, d, err, base, ta, tb;
        logic hold_v;

        // R1: reset state
        rst_n = 1'b0; div_mode = 1'b0; div_sel = 1'b0;
        half_en = 1'b1; ref_8k = 1'b1; ext_clk = 1'b0;
        repeat (2) @(negedge clk);
        check("R1 line_clk in reset", line_clk, 0);
        check("R1 line_clk_n in reset", line_clk_n, 1);
        check("R1 frame_8k in reset", frame_8k, 0);
        check("R1 frame_tick in reset", frame_tick, 0);

        // R2/R3: line clock shape after reset
        do_reset(1'b0, 1'b0);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            check($sformatf("R2 line_clk after tick %0d", k), line_clk, ((k % 16) >= 8) ? 1 : 0);
            check("R3 inverse output", line_clk_n, line_clk ? 0 : 1);
        end

        // R5: freeze without enable
        repeat (3) @(negedge clk);
        half_en = 1'b0;
        @(negedge clk);
        hold_v = line_clk;
        repeat (5) begin
            @(negedge clk);
            check("R5 line_clk frozen", line_clk, hold_v);
        end
        half_en = 1'b1;

        // R4/R9: free frame spacing and frame_8k threshold
        wait_tick(t1);
        check("R9 frame_8k low at tick", frame_8k, 0);
        repeat (1039) @(negedge clk);
        check("R9 frame_8k below 65 lines", frame_8k, 0);
        @(negedge clk);
        check("R9 frame_8k at 65 lines", frame_8k, 1);
        wait_tick(t2);
        check("R4 free frame spacing", t2 - t1, 3088);
        @(negedge clk);
        check("R4 tick one cycle", frame_tick, 0);

        // R6: early falling edge sets slowing
        repeat (3) @(negedge clk);
        ref_8k = 1'b0;
        repeat (10) @(negedge clk);
        ref_8k = 1'b1;
        wait_tick(t3);
        wait_tick(t4);
        wait_tick(t5);
        check("R6 stretched frame a", t4 - t3, 3090);
        check("R6 stretched frame b", t5 - t4, 3090);

        // R6: late falling edge clears slowing
        repeat (2000) @(negedge clk);
        ref_8k = 1'b0;
        repeat (10) @(negedge clk);
        ref_8k = 1'b1;
        wait_tick(t6);
        wait_tick(t7);
        wait_tick(t8);
        check("R6 cleared frame a", t7 - t6, 3088);
        check("R6 cleared frame b", t8 - t7, 3088);

        // R5: half-rate enable doubles the frame spacing
        do_reset(1'b0, 1'b0);
        ta = 0; tb = 0;
        while (tb == 0) begin
            @(negedge clk);
            if (frame_tick) begin
                if (ta == 0) ta = cyc;
                else         tb = cyc;
            end
            half_en = ~half_en;
        end
        half_en = 1'b1;
        check("R5 half-rate frame spacing", tb - ta, 6176);

        // R7: pull-in and lock to a slightly slow reference
        do_reset(1'b0, 1'b0);
        wait_tick(t1);
        fall_at = t1 + 12;
        for (int k = 0; k < 32; k++) begin
            while (cyc < fall_at) @(negedge clk);
            ref_8k = 1'b0;
            d   = cyc - last_tick;
            err = (d < 1544) ? d : 3089 - d;
            if (k >= 20) begin
                n_chk++;
                if (err > 24) begin
                    n_bad++;
                    $display("FAIL R7 lock frame %0d: actual %0d expected <= 24", k, err);
                end
            end
            repeat (20) @(negedge clk);
            ref_8k = 1'b1;
            fall_at += 3089;
        end

        // R8/R9: divide mode vector table
        for (int v = 0; v < NVEC; v++) begin
            do_reset(1'b1, VECS[v].sel);
            @(negedge clk);
            base = tick_cnt;
            for (int e = 0; e < int'(VECS[v].edges); e++) begin
                ext_clk = 1'b1;
                repeat (4) @(negedge clk);
                ext_clk = 1'b0;
                repeat (4) @(negedge clk);
            end
            repeat (6) @(negedge clk);
            check($sformatf("R9 divide frame_8k vec %0d", v), frame_8k, int'(VECS[v].exp8k));
            check($sformatf("R8 divide ticks vec %0d", v), tick_cnt - base, int'(VECS[v].ticks));
            check($sformatf("R8 line_clk follows ext vec %0d", v), line_clk, 0);
        end

        // R8: line_clk follows a held-high external clock
        ext_clk = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 line_clk before delay", line_clk, 0);
        @(negedge clk);
        check("R8 line_clk after delay", line_clk, 1);
        check("R3 inverse in divide mode", line_clk_n, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule